// File: doc/BRIEF.md
# Serial Management Interface Controller

This block runs clause-22 management transactions to an external PHY over a two-wire serial bus: a management clock it generates, and a bidirectional data line that it drives through a separate output and output-enable pin and samples through an input pin. Software reaches it through a small word-wide register port. The control register carries the clock divisor, the preamble-suppression option and a soft reset. The command register starts a transaction. The data register carries write data in and read data out. The status register shows a busy flag.

A write starts by loading the data register and then writing a command word with the write bit set. A read starts with a command word that has the read bit set. Software then polls the busy flag, and once it clears, it fetches the result from the data register. While a frame is on the wire, the block ignores any further commands. The divisor and the preamble option are latched when a command is accepted, so they apply to that whole frame.

Top module: `mgmt_serial_ctrl`

## Requirements
- R1: Register offsets on `reg_addr` are 0 control, 1 command, 2 data and 3 status. After reset, status reads 0, data reads 0, command reads 0, and control reads the default divisor field (39) in bits 15:9, with suppression (bit 8) and soft reset (bit 0) both 0.
- R2: A command write that has bit 15 (read) or bit 14 (write) set is accepted when the block is idle. Status bit 0 reads 1 from the cycle after the accepting edge. It stays 1 for exactly N·D cycles, where N is 64 frame bits, or 32 with suppression, and D is the effective divisor.
- R3: The data line carries bits in this order, most significant first in each field: 32 ones (unless suppressed), start 0 1, opcode (1 0 read, 0 1 write), PHY address from command bits 9:5, register address from command bits 4:0, turnaround, then 16 data bits. A write drives turnaround 1 0 and the data register contents as they stood at acceptance.
- R4: On a read, the output-enable is low from the first turnaround bit through the last data bit. The data-line input is sampled on each rising management-clock edge of the 16 data bits. The assembled value is in the data register in the cycle that busy reads 0.
- R5: The effective divisor D is the control field in bits 15:9 plus one, with any result below 2 raised to 2. Each bit period lasts D system cycles: the clock is low for floor(D/2) cycles and high for the rest. The clock is low whenever the block is idle.
- R6: Control bit 8 set at acceptance omits the 32-bit preamble, so the frame begins with the start bits.
- R7: A command written while busy reads 1 has no effect on the frame in flight. A command word with both start bits set runs a read. A command word with neither bit set starts nothing.
- R8: Writing control with bit 0 set aborts any frame, clears the data register and returns divisor and suppression to their defaults. Bit 0 then reads 1 for RST_CYCLES cycles (default 4) and clears by itself. Register writes during that time are ignored.
- R9: When idle, output-enable and data-line output are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data-line output value |
| mdio_oe | output | 1 | Data-line output enable |
| mdio_i | input | 1 | Data-line input |

## Verification
The bench aims at several corner cases. An odd divisor catches a design that splits the low and high phases unevenly or stretches the bit period, because the clock waveform and the busy length both drift. A divisor field of 0 catches a missing clamp, which would stall the clock or run a zero-length bit. A read with both start bits set catches a design that drives the data line in the turnaround. It also catches one that samples a bit late, because the returned word comes back shifted. A command written in the middle of a read, and one written during soft reset, would restart or corrupt the frame if the guard were missing. An abort mid-frame would leave the clock toggling or busy stuck.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int SUP_BIT    = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef enum logic {SQ_IDLE, SQ_RUN} seq_state_e;

  // Effective clock divisor: field plus one, never below two.
  function automatic logic [15:0] eff_div(input logic [15:0] m1);
    return (m1 == 16'd0) ? 16'd2 : m1 + 16'd1;
  endfunction

  // Whole 64-bit frame image, bit 63 leaves first.
  function automatic logic [63:0] build_frame(input logic is_rd,
                                              input logic [4:0] phy,
                                              input logic [4:0] regad,
                                              input logic [15:0] wdat);
    logic [1:0] op;
    op = is_rd ? 2'b10 : 2'b01;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regad, 2'b10, wdat};
  endfunction

endpackage

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import mgmt_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int DIV_LSB    = 9,
  parameter int DEF_DIV_M1 = 39,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             busy,
  input  logic             rd_done,
  input  logic [15:0]      rd_value,
  output logic [DIV_W-1:0] div_m1,
  output logic             sup,
  output logic [15:0]      data_q,
  output logic             go,
  output logic             go_rd,
  output logic [4:0]       phy,
  output logic [4:0]       regad,
  output logic             srst_hit,
  output logic             srst_act
);

  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] rcnt;
  logic          wr_ctrl;
  logic          wr_data;
  logic          unused_bits;

  assign srst_act = (rcnt != '0);
  assign wr_ctrl  = wr && (addr == A_CTRL) && !srst_act;
  assign wr_data  = wr && (addr == A_DATA) && !srst_act;
  assign srst_hit = wr_ctrl && wdata[0];
  assign go       = wr && (addr == A_CMD) && !srst_act && !busy &&
                    (wdata[15] || wdata[14]);
  assign go_rd    = wdata[15];
  assign phy      = wdata[9:5];
  assign regad    = wdata[4:0];
  assign unused_bits = ^{wdata[31:16], wdata[13:10], wdata[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n)        rcnt <= '0;
    else if (srst_hit) rcnt <= RW'(RST_CYCLES);
    else if (srst_act) rcnt <= rcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst_hit) begin
      div_m1 <= DIV_W'(DEF_DIV_M1);
      sup    <= 1'b0;
    end else if (wr_ctrl) begin
      div_m1 <= wdata[DIV_LSB +: DIV_W];
      sup    <= wdata[SUP_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst_hit) data_q <= '0;
    else if (rd_done)       data_q <= rd_value;
    else if (wr_data)       data_q <= wdata[15:0];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = (32'(div_m1) << DIV_LSB) | (32'(sup) << SUP_BIT) |
                      32'(srst_act);
      A_CMD:  rdata = '0;
      A_DATA: rdata = 32'(data_q);
      A_STAT: rdata = 32'(busy);
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int DIV_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           clr,
  input  logic [DIV_W:0] div,
  output logic           mdc,
  output logic           rise_evt,
  output logic           bit_end
);

  logic [DIV_W:0] cnt;
  logic [DIV_W:0] half;

  assign half     = div >> 1;
  assign bit_end  = run && (cnt == div - 1'b1);
  assign rise_evt = run && (cnt == half - 1'b1);
  assign mdc      = run && (cnt >= half);

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (!run || clr || bit_end) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_rd,
  input  logic [4:0]       phy,
  input  logic [4:0]       regad,
  input  logic [15:0]      wr_data,
  input  logic [DIV_W-1:0] div_m1,
  input  logic             sup,
  input  logic             abort,
  input  logic             rise_evt,
  input  logic             bit_end,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             rd_done,
  output logic [15:0]      rd_value,
  output logic [5:0]       bit_idx,
  output logic             rd_op,
  output logic [DIV_W:0]   div_eff
);

  localparam logic [5:0] LAST = 6'(FRAME_BITS - 1);

  seq_state_e  state;
  logic [63:0] frame;
  logic [15:0] sh;
  logic        last_bit;

  assign busy     = (state == SQ_RUN);
  assign last_bit = (bit_idx == LAST);
  assign rd_value = sh;
  assign rd_done  = busy && bit_end && last_bit && rd_op && !abort;
  assign mdio_oe  = busy && !(rd_op && (bit_idx >= 6'(TA_IDX)));
  assign mdio_o   = mdio_oe && frame[LAST - bit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      frame   <= '0;
      bit_idx <= '0;
      rd_op   <= 1'b0;
      div_eff <= (DIV_W + 1)'(2);
      sh      <= '0;
    end else if (abort) begin
      state <= SQ_IDLE;
    end else begin
      case (state)
        SQ_IDLE: if (go) begin
          state   <= SQ_RUN;
          frame   <= build_frame(go_rd, phy, regad, wr_data);
          bit_idx <= sup ? 6'(PRE_BITS) : 6'd0;
          rd_op   <= go_rd;
          div_eff <= (DIV_W + 1)'(eff_div(16'(div_m1)));
        end
        SQ_RUN: begin
          if (rise_evt && rd_op && (bit_idx >= 6'(DATA_IDX)))
            sh <= {sh[14:0], mdio_i};
          if (bit_end) begin
            if (last_bit) state <= SQ_IDLE;
            else          bit_idx <= bit_idx + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mgmt_serial_ctrl.sv
module mgmt_serial_ctrl
  import mgmt_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int DIV_LSB    = 9,
  parameter int DEF_DIV_M1 = 39,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic [DIV_W-1:0] div_m1_w;
  logic [DIV_W:0]   div_eff_w;
  logic             sup_w;
  logic [15:0]      data_w;
  logic             go_w;
  logic             go_rd_w;
  logic [4:0]       phy_w;
  logic [4:0]       regad_w;
  logic             srst_hit_w;
  logic             srst_act_w;
  logic             busy_w;
  logic             rd_done_w;
  logic [15:0]      rd_value_w;
  logic [5:0]       bit_idx_w;
  logic             rd_op_w;
  logic             rise_w;
  logic             bit_end_w;
  logic             cmd_wr_w;

  assign cmd_wr_w = reg_wr && (reg_addr == A_CMD);

  mgmt_regs #(
    .DIV_W(DIV_W), .DIV_LSB(DIV_LSB),
    .DEF_DIV_M1(DEF_DIV_M1), .RST_CYCLES(RST_CYCLES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy_w),
    .rd_done(rd_done_w), .rd_value(rd_value_w), .div_m1(div_m1_w),
    .sup(sup_w), .data_q(data_w), .go(go_w), .go_rd(go_rd_w),
    .phy(phy_w), .regad(regad_w), .srst_hit(srst_hit_w),
    .srst_act(srst_act_w)
  );

  mgmt_frame_seq #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_w), .go_rd(go_rd_w), .phy(phy_w),
    .regad(regad_w), .wr_data(data_w), .div_m1(div_m1_w), .sup(sup_w),
    .abort(srst_hit_w), .rise_evt(rise_w), .bit_end(bit_end_w),
    .mdio_i(mdio_i), .busy(busy_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done_w), .rd_value(rd_value_w), .bit_idx(bit_idx_w),
    .rd_op(rd_op_w), .div_eff(div_eff_w)
  );

  mgmt_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .clr(srst_hit_w),
    .div(div_eff_w), .mdc(mdc), .rise_evt(rise_w), .bit_end(bit_end_w)
  );

endmodule

// File: rtl/mgmt_serial_ctrl_chk.sv
module mgmt_serial_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy,
  input logic       rd_op,
  input logic       srst_act,
  input logic       cmd_wr,
  input logic [5:0] bit_idx
);

  // R5
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdio_o));

  // R3
  preamble_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (bit_idx < 6'd32)) |-> (mdio_oe && mdio_o));

  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_op && (bit_idx >= 6'd48)) |-> !mdio_oe);

  // R8
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_act |-> !busy);

  // R2
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !srst_act) |-> ($past(bit_idx) == 6'd63));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(rd_op));

endmodule

bind mgmt_serial_ctrl mgmt_serial_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy_w), .rd_op(rd_op_w), .srst_act(srst_act_w),
  .cmd_wr(cmd_wr_w), .bit_idx(bit_idx_w)
);

// File: tb/test_mgmt_serial_ctrl.sv
`timescale 1ns/1ps
module test_mgmt_serial_ctrl;

  localparam int RSTC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd3;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural model state
  bit          m_active = 0;
  bit          m_rd = 0;
  int          m_t = 0;
  int          m_dlat = 2;
  int          m_start = 0;
  int          m_div = 39;
  bit          m_sup = 0;
  int          m_srl = 0;
  logic [15:0] m_data = '0;
  logic [15:0] m_wdat = '0;
  logic [4:0]  m_phy = '0;
  logic [4:0]  m_reg = '0;
  logic [15:0] m_phyval = '0;

  mgmt_serial_ctrl i_mgmt_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int m1);
    if (m1 < 1) return 2;
    return m1 + 1;
  endfunction

  function automatic bit fbit(input int k);
    if (k < 32)  return 1'b1;
    if (k == 32) return 1'b0;
    if (k == 33) return 1'b1;
    if (k == 34) return m_rd;
    if (k == 35) return !m_rd;
    if (k <= 40) return m_phy[40 - k];
    if (k <= 45) return m_reg[45 - k];
    if (k == 46) return 1'b1;
    if (k == 47) return 1'b0;
    return m_wdat[63 - k];
  endfunction

  task automatic model_edge();
    bit done_now;
    done_now = 0;
    if (!rst_n) return;
    if (m_srl > 0) begin m_srl--; return; end
    if (reg_wr && reg_addr == 2'd0 && reg_wdata[0]) begin
      m_srl = RSTC; m_active = 0; m_div = 39; m_sup = 0; m_data = '0;
      return;
    end
    if (m_active) begin
      m_t++;
      if (m_t == (64 - m_start) * m_dlat) begin
        m_active = 0;
        if (m_rd) begin m_data = m_phyval; done_now = 1; end
      end
    end else if (reg_wr && reg_addr == 2'd1 && (reg_wdata[15] || reg_wdata[14])) begin
      m_active = 1; m_t = 0; m_rd = reg_wdata[15];
      m_phy = reg_wdata[9:5]; m_reg = reg_wdata[4:0]; m_wdat = m_data;
      m_dlat = eff(m_div); m_start = m_sup ? 32 : 0;
    end
    if (reg_wr && reg_addr == 2'd0) begin
      m_div = int'(reg_wdata[15:9]); m_sup = reg_wdata[8];
    end
    if (reg_wr && reg_addr == 2'd2 && !done_now) m_data = reg_wdata[15:0];
  endtask

  task automatic compare();
    int ph, bk;
    bit e_mdc, e_oe, e_mdo;
    logic [31:0] e_rd;
    string tag;
    e_mdc = 0; e_oe = 0; e_mdo = 0; bk = 0;
    if (m_active) begin
      ph = m_t % m_dlat;
      bk = m_start + m_t / m_dlat;
      e_mdc = (ph >= m_dlat / 2);
      e_oe = !(m_rd && bk >= 46);
      e_mdo = e_oe ? fbit(bk) : 1'b0;
    end
    mdio_i = (m_active && m_rd && bk >= 48) ? m_phyval[63 - bk] : 1'b1;
    case (reg_addr)
      2'd0: begin e_rd = (32'(m_div) << 9) | (32'(m_sup) << 8) | 32'(m_srl > 0); tag = "R8"; end
      2'd1: begin e_rd = '0; tag = "R1"; end
      2'd2: begin e_rd = 32'(m_data); tag = "R4"; end
      default: begin e_rd = 32'(m_active); tag = "R2"; end
    endcase
    chk(mdc === e_mdc, "R5", "mdc", mdc, e_mdc);
    chk(mdio_oe === e_oe, m_active ? "R4" : "R9", "mdio_oe", mdio_oe, e_oe);
    chk(mdio_o === e_mdo, "R3", "mdio_o", mdio_o, e_mdo);
    chk(reg_rdata === e_rd, tag, "reg_rdata", reg_rdata, e_rd);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc();
    reg_wr = 1'b0; reg_addr = 2'd3; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // counts busy cycles from the cycle after acceptance
  task automatic busy_len(output int n);
    logic [31:0] v;
    n = 0;
    rd_reg(2'd3, v);
    while (v[0] && n < 20000) begin
      n++;
      cyc();
      rd_reg(2'd3, v);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog expired: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    rd_reg(2'd3, v); chk(v == 32'd0, "R1", "status after reset", v, 0);
    rd_reg(2'd0, v); chk(v == (32'd39 << 9), "R1", "control after reset", v, 32'd39 << 9);
    rd_reg(2'd2, v); chk(v == 32'd0, "R1", "data after reset", v, 0);
    rd_reg(2'd1, v); chk(v == 32'd0, "R1", "command readback", v, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9", "idle pins", {mdc, mdio_oe}, 0);

    // R3 write frame with preamble, D=4
    wr_reg(2'd0, 32'(3) << 9);
    wr_reg(2'd2, 32'h0000_A5C3);
    wr_reg(2'd1, 32'h0000_4000 | (32'h12 << 5) | 32'h07);
    busy_len(n);
    chk(n == 256, "R2", "write busy cycles D=4", n, 256);

    // R6 read with suppression, odd divisor D=5
    m_phyval = 16'h3C5A;
    wr_reg(2'd0, (32'(4) << 9) | (32'd1 << 8));
    wr_reg(2'd1, 32'h0000_8000 | (32'h01 << 5) | 32'h02);
    busy_len(n);
    chk(n == 160, "R6", "suppressed read busy cycles D=5", n, 160);
    rd_reg(2'd2, v); chk(v == 32'h3C5A, "R4", "read result", v, 32'h3C5A);

    // R7 both start bits run a read, D=2
    m_phyval = 16'h8001;
    wr_reg(2'd0, 32'(1) << 9);
    wr_reg(2'd1, 32'h0000_C000 | (32'h1F << 5) | 32'h1F);
    busy_len(n);
    chk(n == 128, "R7", "both-bits frame length", n, 128);
    rd_reg(2'd2, v); chk(v == 32'h8001, "R7", "both bits gives read data", v, 32'h8001);

    // R7 neither bit starts nothing
    wr_reg(2'd1, 32'h0000_03FF);
    rd_reg(2'd3, v); chk(v == 32'd0, "R7", "no start bit busy", v, 0);
    idle(3);

    // R7 command during a read is ignored, D=4
    m_phyval = 16'h6B1D;
    wr_reg(2'd0, 32'(3) << 9);
    wr_reg(2'd1, 32'h0000_8000 | (32'h03 << 5) | 32'h11);
    idle(20);
    wr_reg(2'd1, 32'h0000_4000 | (32'h1A << 5) | 32'h05);
    busy_len(n);
    chk(n == 256 - 21, "R7", "remaining busy after ignored cmd", n, 256 - 21);
    rd_reg(2'd2, v); chk(v == 32'h6B1D, "R7", "read survives ignored cmd", v, 32'h6B1D);

    // R5 divisor field 0 clamps to 2
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd2, 32'h0000_0F0F);
    wr_reg(2'd1, 32'h0000_4000 | (32'h05 << 5) | 32'h0A);
    busy_len(n);
    chk(n == 128, "R5", "clamped divisor frame length", n, 128);

    // R8 soft reset mid-frame
    wr_reg(2'd0, 32'(3) << 9);
    wr_reg(2'd1, 32'h0000_4000 | (32'h02 << 5) | 32'h03);
    idle(30);
    wr_reg(2'd0, (32'(5) << 9) | 32'd1);
    rd_reg(2'd3, v); chk(v == 32'd0, "R8", "busy after abort", v, 0);
    rd_reg(2'd0, v); chk(v[0] == 1'b1, "R8", "reset flag set", v[0], 1);
    wr_reg(2'd1, 32'h0000_4000);
    idle(RSTC + 2);
    rd_reg(2'd3, v); chk(v == 32'd0, "R8", "command ignored in reset", v, 0);
    rd_reg(2'd0, v); chk(v == (32'd39 << 9), "R8", "control defaults after reset", v, 32'd39 << 9);
    rd_reg(2'd2, v); chk(v == 32'd0, "R8", "data cleared by reset", v, 0);

    // R5 default divisor read, D=40
    m_phyval = 16'h1234;
    wr_reg(2'd1, 32'h0000_8000 | (32'h09 << 5) | 32'h01);
    busy_len(n);
    chk(n == 2560, "R5", "default divisor frame length", n, 2560);
    rd_reg(2'd2, v); chk(v == 32'h1234, "R4", "read result D=40", v, 32'h1234);
    idle(4);

    summary();
    $finish;
  end

endmodule